// File: doc/BRIEF.md
# DRAM Self-Refresh Sleep Controller

This block moves an asynchronous DRAM into its low-power self-refresh state when the host asks to sleep, and brings it back to normal operation when the host asks to wake. It drives the row strobe, column strobe and write enable, all active low, for the duration of the sleep sequence. Normal reads, writes and the periodic refresh timer belong to neighbouring blocks. Those blocks watch the `busy` output, and a separate refresh engine carries out the single refresh cycles that this controller asks for through `refReq`/`refDone`.

An accepted sleep request first has one refresh performed. The controller then pulls the column strobe low ahead of the row strobe with write enable high, and holds the row strobe low for at least the self-refresh minimum. A wake request that arrives earlier is held until that minimum has passed, so the row strobe never rises inside the unusable transition window. On exit both strobes rise together, and the longer post-self-refresh precharge is held under `busy`. A further refresh is then requested and the wake is acknowledged. A sweep counter is cleared at every exit and counts refresh completions. Sleep is refused until the counter shows that every row has been refreshed again.

Top module: `srefresh_ctl`

## Requirements
- R1: While reset is asserted and after its release, `rasN`, `casN` and `weN` are 1 and `busy`, `refReq`, `sleepAck` and `wakeAck` are 0.
- R2: After reset, the sweep count starts at 0. A `sleepReq` is accepted only when the sweep count equals ROWS. Otherwise it has no effect: `busy`, `refReq` and `sleepAck` stay 0, and `casN` stays 1.
- R3: An accepted `sleepReq` raises `busy` and `refReq` one cycle later. Both strobes stay 1 until a `refDone` pulse arrives, however long that takes.
- R4: The cycle after `refDone`, `casN` goes to 0 with `rasN` still 1 for exactly CAS_LEAD cycles. `rasN` then falls while `casN` stays 0. `weN` is 1 throughout.
- R5: `sleepAck` is 1 exactly while `rasN` is held low in self-refresh. That low period lasts at least SR_MIN cycles.
- R6: A `wakeReq` raised earlier than SR_MIN cycles into the low period has no effect until SR_MIN cycles have passed. The strobes rise on the cycle after that. Without `wakeReq`, the DRAM stays in self-refresh indefinitely.
- R7: On exit, `casN` and `rasN` rise in the same cycle. `busy` then stays 1 with both strobes high for exactly EXIT_PRE cycles.
- R8: When the precharge ends, `busy` falls and `refReq` rises. The cycle after `refDone`, `wakeAck` is 1 for one cycle and `refReq` is 0.
- R9: The sweep count is cleared at each exit, increments on each `refDone` (this includes the one after exit), and saturates at ROWS. With one count short of ROWS, a sleep request is refused. After one more `refDone`, the same request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sleepReq | input | 1 | Host request to enter self-refresh; held until `sleepAck` |
| sleepAck | output | 1 | High while the DRAM is held in self-refresh |
| wakeReq | input | 1 | Host request to leave self-refresh; held until `wakeAck` |
| wakeAck | output | 1 | One-cycle pulse when exit and post-exit refresh are complete |
| busy | output | 1 | Blocks the access sequencer from entry until exit precharge ends |
| refReq | output | 1 | Asks the refresh engine for one refresh cycle |
| refDone | input | 1 | One-cycle pulse per completed refresh cycle |
| rasN | output | 1 | Row strobe to the DRAM, active low |
| casN | output | 1 | Column strobe to the DRAM, active low |
| weN | output | 1 | Write enable to the DRAM, active low (held high) |

## Verification
The strobes, `busy`, `refReq` and both acks decode straight from the state register. Each response is therefore visible one clock after the input that caused it: `busy` after an accepted `sleepReq`, falling `casN` after `refDone`, and rising strobes after a `wakeReq` that follows the hold minimum. The CAS lead, hold and precharge periods last exactly CAS_LEAD, SR_MIN and EXIT_PRE clocks from their first cycle. The bench drives inputs on the falling clock edge and samples outputs on later falling edges. Period lengths are counted edge by edge over the whole window rather than at a single point, so a result that comes one cycle early or one cycle late is caught.

// File: rtl/srefresh_pkg.sv
package srefresh_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PREREF,
    S_CASLEAD,
    S_HOLD,
    S_EXITPRE,
    S_POSTREF,
    S_WAKEACK
  } srState_e;

  // control -> datapath
  typedef struct packed {
    logic timerClr;
    logic sweepClr;
  } srStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic leadDone;
    logic holdDone;
    logic preDone;
    logic sweepFull;
  } srFlags_t;

endpackage

// File: rtl/srefresh_dp.sv
module srefresh_dp
  import srefresh_pkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int SR_MIN   = 10000,
  parameter int EXIT_PRE = 9,
  parameter int ROWS     = 2048
) (
  input  logic      clk,
  input  logic      rstN,
  input  srStrobe_t strobe,
  input  logic      refDone,
  output srFlags_t  flags
);

  localparam int TMAX0 = (CAS_LEAD > EXIT_PRE) ? CAS_LEAD : EXIT_PRE;
  localparam int TMAX  = (TMAX0 > SR_MIN) ? TMAX0 : SR_MIN;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int SW    = $clog2(ROWS + 1);
  localparam logic [TW-1:0] T_TOP     = TW'(TMAX);
  localparam logic [SW-1:0] SWEEP_TOP = SW'(ROWS);

  logic [TW-1:0] timer;
  logic [SW-1:0] sweepCnt;

  // phase timer: restarts on every state change, saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '0;
    else if (strobe.timerClr) timer <= '0;
    else if (timer != T_TOP)  timer <= timer + 1'b1;
  end

  // rows refreshed since the last self-refresh exit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  sweepCnt <= '0;
    else if (strobe.sweepClr)                   sweepCnt <= '0;
    else if (refDone && sweepCnt != SWEEP_TOP)  sweepCnt <= sweepCnt + 1'b1;
  end

  assign flags.leadDone  = (timer == TW'(CAS_LEAD - 1));
  assign flags.holdDone  = (timer >= TW'(SR_MIN - 1));
  assign flags.preDone   = (timer == TW'(EXIT_PRE - 1));
  assign flags.sweepFull = (sweepCnt == SWEEP_TOP);

  // R9: sweep count never passes the row total
  a_r9_sweep_bound: assert property (@(posedge clk) disable iff (!rstN)
    sweepCnt <= SWEEP_TOP);

  // R9: an exit empties the sweep
  a_r9_sweep_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sweepClr |=> (sweepCnt == '0));

  // R9: without a refresh or an exit the count holds
  a_r9_sweep_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.sweepClr && !refDone) |=> $stable(sweepCnt));

endmodule

// File: rtl/srefresh_fsm.sv
module srefresh_fsm
  import srefresh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepReq,
  input  logic      wakeReq,
  input  logic      refDone,
  input  srFlags_t  flags,
  output srStrobe_t strobe,
  output logic      rasN,
  output logic      casN,
  output logic      weN,
  output logic      busy,
  output logic      refReq,
  output logic      sleepAck,
  output logic      wakeAck
);

  srState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:    if (sleepReq && flags.sweepFull) nextState = S_PREREF;
      S_PREREF:  if (refDone)                     nextState = S_CASLEAD;
      S_CASLEAD: if (flags.leadDone)              nextState = S_HOLD;
      S_HOLD:    if (wakeReq && flags.holdDone)   nextState = S_EXITPRE;
      S_EXITPRE: if (flags.preDone)               nextState = S_POSTREF;
      S_POSTREF: if (refDone)                     nextState = S_WAKEACK;
      S_WAKEACK:                                  nextState = S_IDLE;
      default:                                    nextState = S_IDLE;
    endcase
  end

  assign strobe.timerClr = (nextState != state);
  assign strobe.sweepClr = (state == S_HOLD) && (nextState == S_EXITPRE);

  assign rasN     = (state != S_HOLD);
  assign casN     = !((state == S_CASLEAD) || (state == S_HOLD));
  assign weN      = 1'b1;
  assign busy     = (state == S_PREREF) || (state == S_CASLEAD) ||
                    (state == S_HOLD)   || (state == S_EXITPRE);
  assign refReq   = (state == S_PREREF) || (state == S_POSTREF);
  assign sleepAck = (state == S_HOLD);
  assign wakeAck  = (state == S_WAKEACK);

  // R4: row strobe falls only after the column strobe has been low
  a_r4_cas_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  // R5/R6: row strobe rises only once the hold minimum has run out
  a_r5_min_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $past(flags.holdDone));

  // R7: column strobe is released no later than the row strobe
  a_r7_cas_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> casN);

  // R7: busy ends only when the exit precharge has elapsed
  a_r7_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(flags.preDone) && rasN));

  // R2: a sleep sequence starts only on a complete sweep
  a_r2_sweep_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(flags.sweepFull));

endmodule

// File: rtl/srefresh_ctl.sv
module srefresh_ctl
  import srefresh_pkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int SR_MIN   = 10000,
  parameter int EXIT_PRE = 9,
  parameter int ROWS     = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  output logic sleepAck,
  input  logic wakeReq,
  output logic wakeAck,
  output logic busy,
  output logic refReq,
  input  logic refDone,
  output logic rasN,
  output logic casN,
  output logic weN
);

  srStrobe_t strobe;
  srFlags_t  flags;

  srefresh_dp #(
    .CAS_LEAD(CAS_LEAD), .SR_MIN(SR_MIN), .EXIT_PRE(EXIT_PRE), .ROWS(ROWS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refDone(refDone), .flags(flags)
  );

  srefresh_fsm u_fsm (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .refDone(refDone), .flags(flags), .strobe(strobe),
    .rasN(rasN), .casN(casN), .weN(weN), .busy(busy), .refReq(refReq),
    .sleepAck(sleepAck), .wakeAck(wakeAck)
  );

endmodule

// File: tb/srefresh_ctl_bench.sv
module srefresh_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CAS_LEAD   = 2;
  localparam int SR_MIN     = 20;
  localparam int EXIT_PRE   = 3;
  localparam int ROWS       = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0, wakeReq = 1'b0, refDone = 1'b0;
  logic sleepAck, wakeAck, busy, refReq, rasN, casN, weN;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srefresh_ctl #(
    .CAS_LEAD(CAS_LEAD), .SR_MIN(SR_MIN), .EXIT_PRE(EXIT_PRE), .ROWS(ROWS)
  ) u_srefresh_ctl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepAck(sleepAck),
    .wakeReq(wakeReq), .wakeAck(wakeAck), .busy(busy), .refReq(refReq),
    .refDone(refDone), .rasN(rasN), .casN(casN), .weN(weN)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseRef(input int n);
    repeat (n) begin
      @(negedge clk) refDone = 1'b1;
      @(negedge clk) refDone = 1'b0;
    end
  endtask

  // R3/R4/R5: entry; returns at the first negedge of the hold
  task automatic enterSleep();
    int lead = 0;
    @(negedge clk) sleepReq = 1'b1;
    @(negedge clk);
    chk("R3 busy after accept", busy, 1);
    chk("R3 refReq after accept", refReq, 1);
    chk("R3 strobes high pre-refresh", {rasN, casN}, 3);
    @(negedge clk);
    chk("R3 waits for refDone", {refReq, casN}, 3);
    refDone = 1'b1;
    @(negedge clk) refDone = 1'b0;
    repeat (CAS_LEAD) begin
      if (!casN && rasN && weN) lead++;
      @(negedge clk);
    end
    chk("R4 cas lead cycles", lead, CAS_LEAD);
    chk("R4 ras low cas low we high", {rasN, casN, weN}, 1);
    chk("R5 sleepAck in hold", sleepAck, 1);
    sleepReq = 1'b0;
  endtask

  // R7/R8: from the first precharge negedge to idle
  task automatic finishWake();
    int pre = 0;
    repeat (EXIT_PRE) begin
      if (busy && rasN && casN) pre++;
      @(negedge clk);
    end
    chk("R7 exit precharge cycles", pre, EXIT_PRE);
    chk("R8 busy low after precharge", busy, 0);
    chk("R8 refReq after precharge", refReq, 1);
    refDone = 1'b1;
    @(negedge clk) refDone = 1'b0;
    wakeReq = 1'b0;
    chk("R8 wakeAck pulse", wakeAck, 1);
    chk("R8 refReq dropped", refReq, 0);
    @(negedge clk);
    chk("R8 wakeAck one cycle", wakeAck, 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {rasN, casN, weN}, 7);
    chk("R1 flags in reset", {busy, refReq, sleepAck, wakeAck}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 strobes after release", {rasN, casN, weN}, 7);
    chk("R1 flags after release", {busy, refReq, sleepAck, wakeAck}, 0);
  endtask

  task automatic testRefusedAtStart();
    int seen = 0;
    sleepReq = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (busy || refReq || sleepAck || !casN) seen++;
    end
    sleepReq = 1'b0;
    chk("R2 sleep refused with empty sweep", seen, 0);
  endtask

  task automatic testEarlyWake();
    int low = 1;
    enterSleep();
    wakeReq = 1'b1;
    repeat (SR_MIN - 1) begin
      @(negedge clk);
      if (!rasN && sleepAck) low++;
    end
    chk("R6 early wake held to minimum", low, SR_MIN);
    @(negedge clk);
    chk("R7 both strobes rise together", {rasN, casN}, 3);
    chk("R5 sleepAck drops on exit", sleepAck, 0);
    chk("R7 busy through exit", busy, 1);
    finishWake();
  endtask

  task automatic testReentryGate();
    int seen = 0;
    pulseRef(ROWS - 2);
    sleepReq = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (busy || refReq || sleepAck || !casN) seen++;
    end
    sleepReq = 1'b0;
    chk("R9 refused one row short", seen, 0);
    pulseRef(1);
  endtask

  task automatic testLateWake();
    enterSleep();
    repeat (SR_MIN + 5) @(negedge clk);
    chk("R6 stays in self-refresh without wake", {rasN, sleepAck}, 1);
    wakeReq = 1'b1;
    @(negedge clk);
    chk("R6 exit one cycle after late wake", {rasN, casN}, 3);
    finishWake();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    testReset();
    testRefusedAtStart();
    pulseRef(ROWS);
    testEarlyWake();
    testReentryGate();
    testLateWake();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule